// File: doc/BRIEF.md
# Byte-Wide Oscillator Tuning Register File

This block holds the tuning words of a numerically controlled oscillator and lets an 8-bit host bus program them one byte at a time. It keeps two 32-bit frequency-step buffers, called A and B, and one 12-bit phase-offset buffer. A 4-bit address picks the buffer and byte lane. A write strobe from the bus commits the byte, and an active-low chip select can block the write. The strobe is asynchronous to the system clock. It passes through a two-flop synchronizer, and its rising edge is then detected in the clock domain.

Two select lines steer the outputs. The frequency select picks which step buffer feeds the accumulator. The phase-source select picks what feeds the phase adder: either the buffered phase word, or a 12-bit word taken directly from the data and address lines. The direct path lets an external modulator change the phase at high speed without going through the bus writes.

Top module: `nco_prog_regs`

## Requirements
- R1: A write is committed once per rising edge of `wr_strobe`. The commit happens on the third rising clock edge after the strobe rises. `addr`, `data` and `cs_n` are sampled in the cycle just before that commit. Changing `data` while the strobe stays high has no effect.
- R2: While `cs_n` is 1, no bus write changes any buffer.
- R3: With `addr[3]`=0, `addr[2]` picks the step buffer (0 = A, 1 = B). `addr[1:0]`=n writes `data` into bits 8n+7:8n of that buffer. The other lanes and the other buffer keep their values.
- R4: With `addr[3]`=1 and `addr[1:0]`=00, `data[7:4]` is written into phase bits 3:0. With `addr[1:0]`=01, `data[7:0]` is written into phase bits 11:4. `addr[2]` is ignored when the phase buffer is addressed.
- R5: A write with `addr[3]`=1 and `addr[1:0]` equal to 10 or 11 changes nothing.
- R6: `step_word` shows buffer A when `freq_sel` is 1 and buffer B when `freq_sel` is 0.
- R7: When `phase_src_sel` is 0, `phase_word` = {`data`, `addr`}, with data in bits 11:4 and address in bits 3:0. This holds whatever the states of `wr_strobe` and `cs_n`.
- R8: When `phase_src_sel` is 1, `phase_word` shows the buffered 12-bit phase register.
- R9: While `rst_n` is low, all buffers read as zero, without waiting for a clock edge.
- R10: Byte lanes may be written in any order. A lane that is not rewritten keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Bus write strobe, asynchronous; rising edge commits |
| cs_n | input | 1 | Active-low chip select for bus writes |
| addr | input | 4 | Target/lane address; low phase bits in direct mode |
| data | input | 8 | Bus data byte; high phase bits in direct mode |
| freq_sel | input | 1 | 1 selects step buffer A, 0 selects B |
| phase_src_sel | input | 1 | 1 selects buffered phase, 0 selects direct bus word |
| step_word | output | 32 | Selected frequency step word |
| phase_word | output | 12 | Selected phase offset word |

## Verification
The bench builds the block with its defaults: 8-bit data, four lanes per step buffer and a two-stage strobe synchronizer. With these values every lane of both step buffers and both halves of the phase word can be reached from the 4-bit address. The three-cycle commit latency is short enough for the bench to change data while the strobe is still held high and show that only the first captured byte lands. The bench also covers the unmapped phase addresses, the blocked chip select, and a reset in the middle of the run, all at the same sizes.

// File: rtl/nco_prog_pkg.sv
package nco_prog_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_STEP  = 2'd1,
    TGT_PH_LO = 2'd2,
    TGT_PH_HI = 2'd3
  } tgt_e;

  // Bit 3 separates step buffers from the phase buffer; bits 1:0 pick the lane.
  function automatic tgt_e decode_target(input logic [3:0] a);
    tgt_e t;
    if (!a[3]) begin
      t = TGT_STEP;
    end else begin
      case (a[1:0])
        2'b00:   t = TGT_PH_LO;
        2'b01:   t = TGT_PH_HI;
        default: t = TGT_NONE;
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/nco_strobe_sync.sv
module nco_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic rise_pulse
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN-2:0], strobe_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/nco_step_bank.sv
module nco_step_bank #(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     bank_sel,
  input  logic [1:0]               lane_sel,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W*LANES-1:0]  step_a,
  output logic [DATA_W*LANES-1:0]  step_b
);
  localparam int NBANK = 2;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic              lane_en;
      logic [DATA_W-1:0] lane_q;

      assign lane_en = wr_en && (int'(bank_sel) == b) && (int'(lane_sel) == l);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q <= '0;
        else if (lane_en) lane_q <= wdata;
      end

      if (b == 0) begin : g_a
        assign step_a[l*DATA_W +: DATA_W] = lane_q;
      end else begin : g_b
        assign step_b[l*DATA_W +: DATA_W] = lane_q;
      end
    end
  end
endmodule

// File: rtl/nco_phase_buf.sv
module nco_phase_buf #(
  parameter int DATA_W = 8,
  parameter int LO_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_lo,
  input  logic                    we_hi,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W+LO_W-1:0]  ph_q
);
  logic [LO_W-1:0]   lo_q;
  logic [DATA_W-1:0] hi_q;

  // Low part takes the upper bits of the byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (we_lo) lo_q <= wdata[DATA_W-1 -: LO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (we_hi) hi_q <= wdata;
  end

  assign ph_q = {hi_q, lo_q};
endmodule

// File: rtl/nco_prog_regs.sv
module nco_prog_regs #(
  parameter int DATA_W      = 8,
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_strobe,
  input  logic                        cs_n,
  input  logic [3:0]                  addr,
  input  logic [DATA_W-1:0]           data,
  input  logic                        freq_sel,
  input  logic                        phase_src_sel,
  output logic [DATA_W*LANES-1:0]     step_word,
  output logic [DATA_W+4-1:0]         phase_word
);
  import nco_prog_pkg::*;

  localparam int ADDR_W  = 4;
  localparam int STEP_W  = DATA_W * LANES;
  localparam int PHASE_W = DATA_W + ADDR_W;

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               wr_go;
  logic               wr_ok;
  tgt_e               tgt;
  logic [STEP_W-1:0]  buf_a;
  logic [STEP_W-1:0]  buf_b;
  logic [PHASE_W-1:0] ph_buf;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1] & rst_n;

  nco_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .strobe_async (wr_strobe),
    .rise_pulse   (wr_go)
  );

  always_comb begin
    wr_ok = wr_go & ~cs_n;
    tgt   = decode_target(addr);
  end

  nco_step_bank #(.DATA_W(DATA_W), .LANES(LANES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_ok && (tgt == TGT_STEP)),
    .bank_sel (addr[2]),
    .lane_sel (addr[1:0]),
    .wdata    (data),
    .step_a   (buf_a),
    .step_b   (buf_b)
  );

  nco_phase_buf #(.DATA_W(DATA_W), .LO_W(ADDR_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we_lo (wr_ok && (tgt == TGT_PH_LO)),
    .we_hi (wr_ok && (tgt == TGT_PH_HI)),
    .wdata (data),
    .ph_q  (ph_buf)
  );

  always_comb begin
    step_word  = freq_sel      ? buf_a  : buf_b;
    phase_word = phase_src_sel ? ph_buf : {data, addr};
  end
endmodule

// File: rtl/nco_prog_chk.sv
module nco_prog_chk #(
  parameter int DATA_W = 8,
  parameter int STEP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [3:0]        addr,
  input logic [DATA_W-1:0] data,
  input logic              phase_src_sel,
  input logic [DATA_W+3:0] phase_word,
  input logic              wr_go,
  input logic [STEP_W-1:0] buf_a,
  input logic [STEP_W-1:0] buf_b,
  input logic [DATA_W+3:0] ph_buf
);
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);

  p_no_pulse_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(buf_a) && $stable(buf_b) && $stable(ph_buf));

  p_cs_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && cs_n) |=> $stable(buf_a) && $stable(buf_b) && $stable(ph_buf));

  p_bank_a_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !cs_n && !addr[3] && !addr[2]) |=> $stable(buf_b) && $stable(ph_buf));

  p_phase_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !cs_n && addr[3] && addr[1:0] == 2'b01)
      |=> ph_buf[DATA_W+3:4] == $past(data) && ph_buf[3:0] == $past(ph_buf[3:0]));

  p_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && addr[3] && addr[1]) |=> $stable(buf_a) && $stable(buf_b) && $stable(ph_buf));

  p_direct_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_src_sel && $stable(phase_src_sel) && $stable(data) && $stable(addr))
      |-> $stable(phase_word));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r9: assert (buf_a == '0 && buf_b == '0 && ph_buf == '0);
    end
  end
endmodule

bind nco_prog_regs nco_prog_chk #(.DATA_W(DATA_W), .STEP_W(DATA_W*LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_n          (cs_n),
  .addr          (addr),
  .data          (data),
  .phase_src_sel (phase_src_sel),
  .phase_word    (phase_word),
  .wr_go         (wr_go),
  .buf_a         (buf_a),
  .buf_b         (buf_b),
  .ph_buf        (ph_buf)
);

// File: tb/nco_prog_regs_test.sv
module nco_prog_regs_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       req;
    logic [31:0] exp_step;
    logic [11:0] exp_ph;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_strobe;
  logic        cs_n;
  logic [3:0]  addr;
  logic [7:0]  data;
  logic        freq_sel;
  logic        phase_src_sel;
  logic [31:0] step_word;
  logic [11:0] phase_word;

  logic [31:0] ma, mb;
  logic [11:0] mp;
  item_t       sb_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_prog_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .cs_n(cs_n),
    .addr(addr), .data(data), .freq_sel(freq_sel), .phase_src_sel(phase_src_sel),
    .step_word(step_word), .phase_word(phase_word)
  );

  // Monitor: pops expected items and compares away from the clock edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (step_word !== it.exp_step || phase_word !== it.exp_ph) begin
        n_fail++;
        $display("FAIL %s: step=%h phase=%h expected step=%h phase=%h",
                 it.req, step_word, phase_word, it.exp_step, it.exp_ph);
      end
    end
  end

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    if (!a[3]) begin
      if (!a[2]) ma[8*a[1:0] +: 8] = d;
      else       mb[8*a[1:0] +: 8] = d;
    end else if (a[1:0] == 2'b00) begin
      mp[3:0] = d[7:4];
    end else if (a[1:0] == 2'b01) begin
      mp[11:4] = d;
    end
  endtask

  task automatic bus_write(input logic csn, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = csn; addr = a; data = d;
    @(negedge clk); wr_strobe = 1'b1;
    repeat (4) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    if (!csn) model_write(a, d);
  endtask

  task automatic expect_out(input string req, input logic fs, input logic ps);
    item_t it;
    @(negedge clk);
    freq_sel = fs; phase_src_sel = ps;
    it.req      = req;
    it.exp_step = fs ? ma : mb;
    it.exp_ph   = ps ? mp : {data, addr};
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_strobe = 1'b0; cs_n = 1'b1; addr = '0; data = '0;
    freq_sel = 1'b1; phase_src_sel = 1'b1;
    ma = '0; mb = '0; mp = '0;
    repeat (3) @(negedge clk);
    expect_out("R9 reset A", 1'b1, 1'b1);
    expect_out("R9 reset B", 1'b0, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R10: buffer A lanes in scrambled order
    bus_write(1'b0, 4'b0011, 8'hDE);
    bus_write(1'b0, 4'b0000, 8'hEF);
    bus_write(1'b0, 4'b0010, 8'hAD);
    bus_write(1'b0, 4'b0001, 8'hBE);
    expect_out("R3 R6 buffer A lanes", 1'b1, 1'b1);
    expect_out("R3 R6 buffer B untouched", 1'b0, 1'b1);

    bus_write(1'b0, 4'b0101, 8'h34);
    bus_write(1'b0, 4'b0111, 8'h12);
    expect_out("R3 buffer B lanes", 1'b0, 1'b1);
    expect_out("R10 buffer A retained", 1'b1, 1'b1);

    bus_write(1'b0, 4'b0010, 8'h55);
    expect_out("R10 single lane rewrite", 1'b1, 1'b1);

    // R2: chip select high blocks
    bus_write(1'b1, 4'b0000, 8'h00);
    bus_write(1'b1, 4'b1001, 8'hFF);
    expect_out("R2 blocked write A", 1'b1, 1'b1);
    expect_out("R2 blocked write B", 1'b0, 1'b1);

    // R4/R8: phase buffer halves, addr[2] ignored
    bus_write(1'b0, 4'b1000, 8'hA5);
    expect_out("R4 R8 phase low nibble", 1'b1, 1'b1);
    bus_write(1'b0, 4'b1101, 8'h3C);
    expect_out("R4 R8 phase high byte", 1'b1, 1'b1);

    // R5: unmapped phase addresses
    bus_write(1'b0, 4'b1010, 8'h77);
    bus_write(1'b0, 4'b1111, 8'h88);
    expect_out("R5 unmapped A", 1'b1, 1'b1);
    expect_out("R5 unmapped B", 1'b0, 1'b1);

    // R7: direct phase path, strobe low and cs_n high
    @(negedge clk); cs_n = 1'b1; data = 8'h5A; addr = 4'h7;
    expect_out("R7 direct word", 1'b1, 1'b0);
    @(negedge clk); cs_n = 1'b0; data = 8'hC3; addr = 4'hE;
    expect_out("R7 direct word cs low", 1'b0, 1'b0);
    expect_out("R8 buffered after direct", 1'b0, 1'b1);

    // R1: data change while strobe held high is not captured
    @(negedge clk); cs_n = 1'b0; addr = 4'b0001; data = 8'h11;
    @(negedge clk); wr_strobe = 1'b1;
    repeat (4) @(negedge clk);
    data = 8'h99;
    repeat (4) @(negedge clk);
    wr_strobe = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    model_write(4'b0001, 8'h11);
    expect_out("R1 first captured byte kept", 1'b1, 1'b1);

    // R9: reset during operation
    @(negedge clk); rst_n = 1'b0;
    ma = '0; mb = '0; mp = '0;
    expect_out("R9 mid-run reset A", 1'b1, 1'b1);
    expect_out("R9 mid-run reset B", 1'b0, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(1'b0, 4'b0100, 8'h6B);
    expect_out("R3 write after reset", 1'b0, 1'b1);

    done = 1;
    finish_run();
  end
endmodule